// File: doc/BRIEF.md
# BCH-8 Sector Parity Encoder

This block produces the check bytes that protect one flash sector against up to eight flipped bits. Data bytes stream in one per accepted beat. Each byte updates a 104-bit division remainder over GF(2^13). The field is built on x^13 + x^4 + x^3 + x + 1, which is 0x201B as a bit mask. The generator polynomial is the product of the minimal polynomials of alpha^1, alpha^3, ..., alpha^15. Its degree is 104, and it is derived from the field definition when the design is elaborated.

When the beat that closes a sector is accepted, the block stops taking input. On the next thirteen consecutive cycles it presents the remainder one byte per cycle. Each byte is XORed with a fixed mask byte. The mask is chosen so that a freshly erased sector of 0xFF bytes yields thirteen 0xFF check bytes, which matches what an erased spare area holds.

A controller upstream marks the first byte of each sector and the last byte. It waits for the ready flag before offering the next sector. It stores the thirteen output bytes next to the data.

Top module: `bch8_sector_encoder`

## Requirements
- R1: After reset, outValid and outLast are 0 and inReady is 1.
- R2: A byte is taken when inValid and inReady are both 1, most significant bit first. The parity is the remainder of D(x)·x^104 divided by the generator polynomial, where D(x) is the sector's bit sequence. The resulting codeword has zero syndromes at alpha^1, alpha^3, ..., alpha^15.
- R3: After the beat carrying inLast is taken, outValid is 1 on exactly the next 13 consecutive cycles. outLast is 1 only on the 13th of those cycles.
- R4: Output byte k (k = 0..12) is remainder bits [103-8k : 96-8k] XORed with mask byte k. The mask bytes are, in order: EF 51 2E 09 ED 93 9A C2 97 79 E5 24 B5.
- R5: A 512-byte sector of all 0xFF yields thirteen 0xFF output bytes.
- R6: A sector of all 0x00 yields exactly the mask bytes of R4.
- R7: A beat taken with inFirst set starts from an empty remainder, so bytes accumulated before it have no effect.
- R8: While parity bytes are output, inReady is 0. Beats offered then are ignored: they change neither that parity nor the next sector's parity.
- R9: Cycles with inValid at 0 between beats leave the result unchanged.
- R10: On the cycle after the 13th parity byte, outValid is 0 and inReady is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input byte offered |
| inFirst | input | 1 | Offered byte opens a sector |
| inLast | input | 1 | Offered byte closes a sector |
| inData | input | 8 | Sector data byte |
| inReady | output | 1 | Input can be taken this cycle |
| outValid | output | 1 | Parity byte present |
| outLast | output | 1 | Present byte is the 13th parity byte |
| outData | output | 8 | Masked parity byte |

## Verification
The properties assume that inputs carry known values and that inLast is raised only on a byte meant to close a sector. They also assume that sectors are short enough for the shortened code: at most 8087 data bits. The stimulus keeps every sector between 1 and 512 bytes and drives all inputs only on falling edges. Beats that arrive during a parity burst are offered on purpose: these are the only beats the stimulus presents while inReady is low.

// File: rtl/bch8_pkg.sv
package bch8_pkg;

  localparam int GF_M      = 13;
  localparam int CORR_T    = 8;
  localparam logic [GF_M:0] GF_POLY = 14'h201B;
  localparam int GF_ORDER  = (1 << GF_M) - 1;
  localparam int PAR_BITS  = GF_M * CORR_T;
  localparam int DATA_W    = 8;
  localparam int PAR_BYTES = PAR_BITS / DATA_W;
  localparam int SLOT_W    = $clog2(PAR_BYTES);

  typedef logic [GF_M-1:0] gfElem_t;

  typedef struct packed {
    logic              clear;
    logic              absorb;
    logic              shift;
    logic [SLOT_W-1:0] slot;
  } bchStrobe_t;

  function automatic gfElem_t gfMul(input gfElem_t a, input gfElem_t b);
    gfElem_t acc;
    gfElem_t x;
    acc = '0;
    x   = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) acc = acc ^ x;
      if (x[GF_M-1]) x = (x << 1) ^ GF_POLY[GF_M-1:0];
      else           x = x << 1;
    end
    return acc;
  endfunction

  function automatic gfElem_t gfPow(input int expo);
    gfElem_t r;
    gfElem_t b;
    int e;
    r = gfElem_t'(1);
    b = gfElem_t'(2);
    e = expo % GF_ORDER;
    for (int i = 0; i < GF_M + 1; i++) begin
      if (e[0]) r = gfMul(r, b);
      b = gfMul(b, b);
      e = e >> 1;
    end
    return r;
  endfunction

  // Product of (x + beta) over all conjugates of alpha^1, alpha^3 .. alpha^(2T-1)
  function automatic logic [PAR_BITS:0] genPoly();
    logic [(PAR_BITS+1)*GF_M-1:0] c;
    logic [PAR_BITS:0] g;
    gfElem_t beta;
    int deg;
    int e;
    c = '0;
    c[0 +: GF_M] = gfElem_t'(1);
    deg = 0;
    for (int k = 0; k < CORR_T; k++) begin
      e = 2 * k + 1;
      for (int j = 0; j < GF_M; j++) begin
        beta = gfPow(e);
        for (int d = deg + 1; d >= 1; d--) begin
          c[d*GF_M +: GF_M] = c[(d-1)*GF_M +: GF_M] ^ gfMul(c[d*GF_M +: GF_M], beta);
        end
        c[0 +: GF_M] = gfMul(c[0 +: GF_M], beta);
        deg = deg + 1;
        e = (e * 2) % GF_ORDER;
      end
    end
    for (int d = 0; d <= PAR_BITS; d++) g[d] = c[d*GF_M];
    return g;
  endfunction

  function automatic logic [DATA_W-1:0] padByte(input logic [SLOT_W-1:0] idx);
    case (idx)
      4'd0:    return 8'hEF;
      4'd1:    return 8'h51;
      4'd2:    return 8'h2E;
      4'd3:    return 8'h09;
      4'd4:    return 8'hED;
      4'd5:    return 8'h93;
      4'd6:    return 8'h9A;
      4'd7:    return 8'hC2;
      4'd8:    return 8'h97;
      4'd9:    return 8'h79;
      4'd10:   return 8'hE5;
      4'd11:   return 8'h24;
      4'd12:   return 8'hB5;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/bch8_ctrl.sv
module bch8_ctrl
  import bch8_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inFirst,
  input  logic       inLast,
  output logic       inReady,
  output logic       outValid,
  output logic       outLast,
  output bchStrobe_t stb
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAR_BYTES - 1);

  typedef enum logic {ST_TAKE, ST_EMIT} ctrlState_t;

  ctrlState_t        state;
  logic [SLOT_W-1:0] slot;
  logic              take;

  assign inReady  = (state == ST_TAKE);
  assign take     = inValid && inReady;
  assign outValid = (state == ST_EMIT);
  assign outLast  = outValid && (slot == LAST_SLOT);

  always_comb begin
    stb.clear  = take && inFirst;
    stb.absorb = take;
    stb.shift  = outValid;
    stb.slot   = slot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_TAKE;
      slot  <= '0;
    end else begin
      case (state)
        ST_TAKE: begin
          slot <= '0;
          if (take && inLast) state <= ST_EMIT;
        end
        ST_EMIT: begin
          if (slot == LAST_SLOT) begin
            state <= ST_TAKE;
            slot  <= '0;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        default: state <= ST_TAKE;
      endcase
    end
  end

endmodule

// File: rtl/bch8_datapath.sv
module bch8_datapath
  import bch8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bchStrobe_t        stb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);

  localparam logic [PAR_BITS:0]   GEN_FULL = genPoly();
  localparam logic [PAR_BITS-1:0] GEN_TAPS = GEN_FULL[PAR_BITS-1:0];

  logic [PAR_BITS-1:0] remReg;
  logic [PAR_BITS-1:0] absorbed;
  logic                fb;

  // Byte-wide division step: eight serial steps unrolled, MSB first
  always_comb begin
    absorbed = stb.clear ? '0 : remReg;
    fb       = 1'b0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb       = inData[b] ^ absorbed[PAR_BITS-1];
      absorbed = {absorbed[PAR_BITS-2:0], 1'b0} ^ ({PAR_BITS{fb}} & GEN_TAPS);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg <= '0;
    end else if (stb.absorb) begin
      remReg <= absorbed;
    end else if (stb.shift) begin
      remReg <= {remReg[PAR_BITS-DATA_W-1:0], {DATA_W{1'b0}}};
    end
  end

  assign outData = remReg[PAR_BITS-1 -: DATA_W] ^ padByte(stb.slot);

endmodule

// File: rtl/bch8_sector_encoder.sv
module bch8_sector_encoder
  import bch8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inFirst,
  input  logic              inLast,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic              outLast,
  output logic [DATA_W-1:0] outData
);

  bchStrobe_t stb;

  bch8_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inFirst  (inFirst),
    .inLast   (inLast),
    .inReady  (inReady),
    .outValid (outValid),
    .outLast  (outLast),
    .stb      (stb)
  );

  bch8_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/bch8_sector_encoder_chk.sv
module bch8_sector_encoder_chk
  import bch8_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inLast,
  input logic inReady,
  input logic outValid,
  input logic outLast
);

  logic [SLOT_W:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         runLen <= '0;
    else if (outValid) runLen <= runLen + 1'b1;
    else               runLen <= '0;
  end

  p_emit_stalls_input_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  p_last_implies_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  p_burst_starts_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> outValid);

  p_burst_continues_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> outValid);

  p_idle_stays_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && !(inValid && inReady && inLast)) |=> !outValid);

  p_burst_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> (runLen == (SLOT_W+1)'(PAR_BYTES - 1)));

  p_burst_ends_r10: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> (!outValid && inReady));

endmodule

bind bch8_sector_encoder bch8_sector_encoder_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inLast   (inLast),
  .inReady  (inReady),
  .outValid (outValid),
  .outLast  (outLast)
);

// File: tb/bch8_sector_encoder_test.sv
module bch8_sector_encoder_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inFirst = 1'b0;
  logic       inLast = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inReady;
  logic       outValid;
  logic       outLast;
  logic [7:0] outData;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] secBuf [512];
  logic [7:0] got [13];
  logic [7:0] ref0 [13];
  logic [7:0] mask [13];

  always #2 clk = ~clk;

  bch8_sector_encoder uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
    .inLast(inLast), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outLast(outLast), .outData(outData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench-side field multiply, MSB-first Horner form
  function automatic logic [12:0] tbMul(input logic [12:0] a, input logic [12:0] b);
    logic [13:0] acc;
    acc = '0;
    for (int i = 12; i >= 0; i--) begin
      acc = acc << 1;
      if (acc[13]) acc = acc ^ 14'h201B;
      if (b[i]) acc = acc ^ {1'b0, a};
    end
    return acc[12:0];
  endfunction

  // Syndromes of data||remainder at odd powers of alpha must all be zero
  function automatic bit codeOk(input int len);
    logic [12:0] a;
    logic [12:0] s;
    logic [7:0]  rb;
    for (int i = 1; i <= 15; i += 2) begin
      a = 13'h1;
      for (int p = 0; p < i; p++) a = tbMul(a, 13'h2);
      s = '0;
      for (int n = 0; n < len; n++)
        for (int b = 7; b >= 0; b--) s = tbMul(s, a) ^ {12'h0, secBuf[n][b]};
      for (int k = 0; k < 13; k++) begin
        rb = got[k] ^ mask[k];
        for (int b = 7; b >= 0; b--) s = tbMul(s, a) ^ {12'h0, rb[b]};
      end
      if (s != 0) return 0;
    end
    return 1;
  endfunction

  task automatic fillSector(input int len, input int kind);
    for (int n = 0; n < len; n++)
      secBuf[n] = (kind == 1) ? 8'hFF : (kind == 2) ? 8'h00 : 8'($urandom);
  endtask

  // Drive a sector, collect 13 parity bytes; optional gaps and stall garbage
  task automatic runSector(input int len, input bit gaps, input bit garbage);
    for (int n = 0; n < len; n++) begin
      if (gaps) begin
        while (($urandom % 4) == 0) begin
          @(negedge clk);
          inValid = 1'b0;
        end
      end
      @(negedge clk);
      inValid = 1'b1;
      inFirst = (n == 0);
      inLast  = (n == len - 1);
      inData  = secBuf[n];
    end
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      chk(outValid === 1'b1, "R3 outValid in burst", 32'(outValid), 32'h1);
      chk(outLast === (k == 12), "R3 outLast position", 32'(outLast), 32'(k == 12));
      chk(inReady === 1'b0, "R8 inReady low in burst", 32'(inReady), 32'h0);
      got[k] = outData;
      if (garbage) begin
        inValid = 1'b1;
        inFirst = 1'($urandom);
        inLast  = 1'($urandom);
        inData  = 8'($urandom);
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    chk(outValid === 1'b0 && inReady === 1'b1, "R10 burst closed",
        {outValid, inReady}, 32'h1);
    inValid = 1'b0;
    inFirst = 1'b0;
    inLast  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    bit same;
    mask[0] = 8'hEF; mask[1] = 8'h51; mask[2]  = 8'h2E; mask[3]  = 8'h09;
    mask[4] = 8'hED; mask[5] = 8'h93; mask[6]  = 8'h9A; mask[7]  = 8'hC2;
    mask[8] = 8'h97; mask[9] = 8'h79; mask[10] = 8'hE5; mask[11] = 8'h24;
    mask[12] = 8'hB5;
    void'($urandom(32'd4021));

    repeat (3) @(negedge clk);
    chk(outValid === 1'b0 && outLast === 1'b0 && inReady === 1'b1, "R1 reset state",
        {outValid, outLast, inReady}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);

    // R5: erased sector
    fillSector(512, 1);
    runSector(512, 0, 0);
    for (int k = 0; k < 13; k++) chk(got[k] == 8'hFF, "R5 erased parity", got[k], 8'hFF);

    // R6 and R4: zero sector gives the mask bytes in order
    fillSector(512, 2);
    runSector(512, 0, 0);
    for (int k = 0; k < 13; k++) chk(got[k] == mask[k], "R6 R4 zero parity", got[k], mask[k]);

    // R2: random sectors, including short ones, checked by syndromes
    for (int t = 0; t < 4; t++) begin
      int len;
      len = (t == 0) ? 1 : (t == 1) ? 37 : 512;
      fillSector(len, 0);
      runSector(len, t == 3, 0);
      chk(codeOk(len), "R2 R4 syndromes zero", 32'h0, 32'h1);
    end

    // Reference for R7, R8, R9
    fillSector(512, 0);
    runSector(512, 0, 0);
    chk(codeOk(512), "R2 reference syndromes", 32'h0, 32'h1);
    for (int k = 0; k < 13; k++) ref0[k] = got[k];

    // R9: idle gaps between beats
    runSector(512, 1, 0);
    same = 1;
    for (int k = 0; k < 13; k++) if (got[k] != ref0[k]) same = 0;
    chk(same, "R9 gaps leave parity unchanged", 32'(same), 32'h1);

    // R8: beats offered during burst are ignored
    runSector(512, 0, 1);
    same = 1;
    for (int k = 0; k < 13; k++) if (got[k] != ref0[k]) same = 0;
    chk(same, "R8 stalled beats ignored (this burst)", 32'(same), 32'h1);
    runSector(512, 0, 0);
    same = 1;
    for (int k = 0; k < 13; k++) if (got[k] != ref0[k]) same = 0;
    chk(same, "R8 stalled beats ignored (next sector)", 32'(same), 32'h1);

    // R7: stray unterminated bytes, then a fresh sector with inFirst
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      inValid = 1'b1;
      inFirst = (n == 0);
      inLast  = 1'b0;
      inData  = 8'($urandom);
    end
    runSector(512, 0, 0);
    same = 1;
    for (int k = 0; k < 13; k++) if (got[k] != ref0[k]) same = 0;
    chk(same, "R7 inFirst clears remainder", 32'(same), 32'h1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule